// File: doc/BRIEF.md
# Paged Address Translation Unit

This unit turns a word address issued by the core into a physical word address. In user mode it looks the address up in a page table kept in main memory. The core supplies the table's base address and its entry count as plain inputs. The unit splits the address into a logical page number and an offset. It rejects pages beyond the table length and fetches the two-word entry for the page. It then checks the entry's valid flag and marks the entry as referenced. It answers with either the translated address or a fault that carries a cause code and the offending logical page.

In kernel mode the address needs no lookup and is handed back as the physical address. Only one request is in flight at a time. The core sees `req_ready` fall when a request is taken, and gets a single-cycle `rsp_valid` pulse when the answer is ready. Page-table words are read and written through a simple request/acknowledge memory port. That port tolerates any number of wait cycles.

Top module: `pgxlat_top`

## Requirements
- R1: A request with `req_kernel`=1 is answered on the cycle after acceptance with `rsp_fault`=0 and `rsp_paddr` equal to the request address, and it makes no memory access.
- R2: With the logical page p = address[14:9] and the table length L = `ptlr`, a user request with p >= L is answered on the cycle after acceptance with `rsp_fault`=1, `rsp_cause`=2 and `rsp_badpage`=p, and it makes no memory access. The page p = L-1 is legal.
- R3: The entry for page p occupies two words. The physical-page word is at `ptbr`+2p and the flag word is at `ptbr`+2p+1. The flag word is read first, and the physical-page word is read only when the entry is valid.
- R4: If bit 1 (valid) of the flag word is 0, the response is `rsp_fault`=1, `rsp_cause`=0 and `rsp_badpage`=p, and nothing is written to memory.
- R5: For a valid entry, `rsp_fault`=0 and `rsp_paddr` = (low 6 bits of the physical-page word) × 512 + offset, where the offset is address[8:0]. The upper bits of that word are ignored.
- R6: For a valid entry whose bit 0 (referenced) is 0, exactly one write is made to the flag word, with data equal to the old flag word with bit 0 set.
- R7: For a valid entry whose referenced bit is already 1, no memory write is made.
- R8: `req_ready` is low from acceptance through the response cycle. `rsp_valid` lasts exactly one cycle, and a `req_valid` raised while busy is neither accepted nor answered.
- R9: Once `mem_req` is raised, it stays high with stable `mem_addr` and `mem_we` until `mem_ack`, whatever the memory latency.
- R10: After reset, `req_ready`=1, `rsp_valid`=0 and `mem_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Unit idle, request accepted when high |
| req_kernel | input | 1 | Request issued in kernel mode |
| req_addr | input | 15 | Logical (or kernel physical) word address |
| ptbr | input | 15 | Page-table base word address |
| ptlr | input | 7 | Page-table entry count |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_cause | output | 3 | Fault cause: 0 invalid page, 2 page out of range |
| rsp_badpage | output | 6 | Logical page of the request |
| rsp_paddr | output | 15 | Translated physical word address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |

## Verification
The hardest state to reach from the ports is a second request that arrives while a walk is stalled on a slow memory access. The bench provokes it by stretching the memory latency to several cycles and raising `req_valid` with a different address mid-walk. It then checks that only the first request is answered, and that no stray response follows. The referenced-bit write-back and its skip are both reached by translating the same page twice: the first access sets the bit, and the second must leave memory untouched.

// File: rtl/pgxlat_pkg.sv
package pgxlat_pkg;
  typedef enum logic [2:0] {
    WS_IDLE,
    WS_RD_FLAGS,
    WS_WR_FLAGS,
    WS_RD_FRAME,
    WS_ANSWER
  } walk_st_t;

  localparam logic [2:0] CAUSE_NOT_PRESENT = 3'd0;
  localparam logic [2:0] CAUSE_OUT_OF_RANGE = 3'd2;

  localparam int FLAG_REF_BIT = 0;
  localparam int FLAG_VALID_BIT = 1;
endpackage

// File: rtl/pgxlat_gate.sv
module pgxlat_gate #(
  parameter int ADDR_W = 15,
  parameter int OFF_W = 9,
  localparam int PG_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [PG_W:0]     in_limit,
  output logic [PG_W-1:0]   lpage,
  output logic [OFF_W-1:0]  offset,
  output logic              in_range
);
  function automatic logic [PG_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] offset_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic page_legal(input logic [PG_W-1:0] p,
                                      input logic [PG_W:0] lim);
    return {1'b0, p} < lim;
  endfunction

  always_comb begin
    lpage    = page_of(in_addr);
    offset   = offset_of(in_addr);
    in_range = page_legal(page_of(in_addr), in_limit);
  end
endmodule

// File: rtl/pgxlat_join.sv
module pgxlat_join #(
  parameter int ADDR_W = 15,
  parameter int OFF_W = 9,
  parameter int DATA_W = 16,
  localparam int PG_W = ADDR_W - OFF_W
) (
  input  logic [DATA_W-1:0] frame_word,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] paddr
);
  function automatic logic [ADDR_W-1:0] join_addr(input logic [DATA_W-1:0] w,
                                                  input logic [OFF_W-1:0] o);
    return {w[PG_W-1:0], o};
  endfunction

  assign paddr = join_addr(frame_word, offset);
endmodule

// File: rtl/pgxlat_walk.sv
module pgxlat_walk
  import pgxlat_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int OFF_W = 9,
  parameter int DATA_W = 16,
  localparam int PG_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_kernel,
  input  logic              start_in_range,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [PG_W-1:0]   start_page,
  input  logic [OFF_W-1:0]  start_offset,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] joined_paddr,
  output logic [OFF_W-1:0]  held_offset,
  output logic              idle,
  output logic              answer,
  output logic              res_fault,
  output logic [2:0]        res_cause,
  output logic [PG_W-1:0]   res_page,
  output logic [ADDR_W-1:0] res_paddr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              ev_entry_missing,
  output logic              ev_ref_written
);
  walk_st_t            st;
  logic [ADDR_W-1:0]   entry_q;
  logic [DATA_W-1:0]   flags_q;
  logic                flag_valid;
  logic                flag_ref;

  assign idle       = (st == WS_IDLE);
  assign answer     = (st == WS_ANSWER);
  assign flag_valid = mem_rdata[FLAG_VALID_BIT];
  assign flag_ref   = mem_rdata[FLAG_REF_BIT];

  assign mem_req   = (st == WS_RD_FLAGS) || (st == WS_WR_FLAGS) || (st == WS_RD_FRAME);
  assign mem_we    = (st == WS_WR_FLAGS);
  assign mem_addr  = (st == WS_RD_FRAME) ? entry_q : entry_q + ADDR_W'(1);
  assign mem_wdata = flags_q | (DATA_W'(1) << FLAG_REF_BIT);

  assign ev_entry_missing = (st == WS_RD_FLAGS) && mem_ack && !flag_valid;
  assign ev_ref_written   = (st == WS_WR_FLAGS) && mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= WS_IDLE;
      entry_q     <= '0;
      flags_q     <= '0;
      held_offset <= '0;
      res_fault   <= 1'b0;
      res_cause   <= '0;
      res_page    <= '0;
      res_paddr   <= '0;
    end else begin
      unique case (st)
        WS_IDLE: begin
          if (start) begin
            entry_q     <= base + ADDR_W'({start_page, 1'b0});
            held_offset <= start_offset;
            res_page    <= start_page;
            res_cause   <= '0;
            res_fault   <= 1'b0;
            if (start_kernel) begin
              res_paddr <= start_addr;
              st        <= WS_ANSWER;
            end else if (!start_in_range) begin
              res_fault <= 1'b1;
              res_cause <= CAUSE_OUT_OF_RANGE;
              st        <= WS_ANSWER;
            end else begin
              st <= WS_RD_FLAGS;
            end
          end
        end
        WS_RD_FLAGS: begin
          if (mem_ack) begin
            flags_q <= mem_rdata;
            if (!flag_valid) begin
              res_fault <= 1'b1;
              res_cause <= CAUSE_NOT_PRESENT;
              st        <= WS_ANSWER;
            end else if (flag_ref) begin
              st <= WS_RD_FRAME;
            end else begin
              st <= WS_WR_FLAGS;
            end
          end
        end
        WS_WR_FLAGS: begin
          if (mem_ack) st <= WS_RD_FRAME;
        end
        WS_RD_FRAME: begin
          if (mem_ack) begin
            res_paddr <= joined_paddr;
            st        <= WS_ANSWER;
          end
        end
        WS_ANSWER: st <= WS_IDLE;
        default:   st <= WS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgxlat_top.sv
module pgxlat_top #(
  parameter int ADDR_W = 15,
  parameter int OFF_W = 9,
  parameter int DATA_W = 16,
  localparam int PG_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_kernel,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] ptbr,
  input  logic [PG_W:0]     ptlr,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [2:0]        rsp_cause,
  output logic [PG_W-1:0]   rsp_badpage,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  logic [PG_W-1:0]   gate_page;
  logic [OFF_W-1:0]  gate_offset;
  logic              gate_in_range;
  logic [OFF_W-1:0]  held_offset;
  logic [ADDR_W-1:0] joined_paddr;
  logic              walk_idle;
  logic              ev_accept;
  logic              ev_range_reject;
  logic              ev_entry_missing;
  logic              ev_ref_written;

  assign req_ready       = walk_idle;
  assign ev_accept       = req_valid && walk_idle;
  assign ev_range_reject = ev_accept && !req_kernel && !gate_in_range;

  pgxlat_gate #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) gate_i (
    .in_addr  (req_addr),
    .in_limit (ptlr),
    .lpage    (gate_page),
    .offset   (gate_offset),
    .in_range (gate_in_range)
  );

  pgxlat_join #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) join_i (
    .frame_word (mem_rdata),
    .offset     (held_offset),
    .paddr      (joined_paddr)
  );

  pgxlat_walk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) walk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .start            (ev_accept),
    .start_kernel     (req_kernel),
    .start_in_range   (gate_in_range),
    .start_addr       (req_addr),
    .start_page       (gate_page),
    .start_offset     (gate_offset),
    .base             (ptbr),
    .joined_paddr     (joined_paddr),
    .held_offset      (held_offset),
    .idle             (walk_idle),
    .answer           (rsp_valid),
    .res_fault        (rsp_fault),
    .res_cause        (rsp_cause),
    .res_page         (rsp_badpage),
    .res_paddr        (rsp_paddr),
    .mem_req          (mem_req),
    .mem_we           (mem_we),
    .mem_addr         (mem_addr),
    .mem_wdata        (mem_wdata),
    .mem_rdata        (mem_rdata),
    .mem_ack          (mem_ack),
    .ev_entry_missing (ev_entry_missing),
    .ev_ref_written   (ev_ref_written)
  );
endmodule

// File: rtl/pgxlat_chk.sv
module pgxlat_chk #(
  parameter int ADDR_W = 15,
  parameter int OFF_W = 9,
  parameter int DATA_W = 16,
  localparam int PG_W = ADDR_W - OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_kernel,
  input logic [ADDR_W-1:0] req_addr,
  input logic [PG_W:0]     ptlr,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [2:0]        rsp_cause,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              ev_accept,
  input logic              ev_entry_missing
);
  assert_kernel_direct_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && req_kernel) |=> (rsp_valid && !rsp_fault && rsp_paddr == $past(req_addr)));

  assert_range_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_kernel && ({1'b0, req_addr[ADDR_W-1:OFF_W]} >= ptlr))
    |=> (rsp_valid && rsp_fault && rsp_cause == 3'd2 && !mem_req));

  assert_missing_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_entry_missing |=> (rsp_valid && rsp_fault && rsp_cause == 3'd0));

  assert_ref_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[0]);

  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);
endmodule

bind pgxlat_top pgxlat_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_valid        (req_valid),
  .req_ready        (req_ready),
  .req_kernel       (req_kernel),
  .req_addr         (req_addr),
  .ptlr             (ptlr),
  .rsp_valid        (rsp_valid),
  .rsp_fault        (rsp_fault),
  .rsp_cause        (rsp_cause),
  .rsp_paddr        (rsp_paddr),
  .mem_req          (mem_req),
  .mem_we           (mem_we),
  .mem_addr         (mem_addr),
  .mem_wdata        (mem_wdata),
  .mem_ack          (mem_ack),
  .ev_accept        (ev_accept),
  .ev_entry_missing (ev_entry_missing)
);

// File: tb/pgxlat_top_tb_top.sv
`timescale 1ns/1ps
module pgxlat_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_kernel = 1'b0;
  logic [14:0] req_addr = '0;
  logic [14:0] ptbr = 15'd1000;
  logic [6:0]  ptlr = 7'd10;
  logic        rsp_valid, rsp_fault;
  logic [2:0]  rsp_cause;
  logic [5:0]  rsp_badpage;
  logic [14:0] rsp_paddr;
  logic        mem_req, mem_we;
  logic [14:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int lat = 0;
  int wcnt = 0;
  int n_rd = 0;
  int n_wr = 0;
  logic [15:0] ram [int];
  int rd_addrs [$];

  always #4 clk = ~clk;

  pgxlat_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kernel(req_kernel), .req_addr(req_addr), .ptbr(ptbr), .ptlr(ptlr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_badpage(rsp_badpage), .rsp_paddr(rsp_paddr), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  function automatic logic [15:0] peek(input int a);
    return ram.exists(a) ? ram[a] : 16'h0000;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model with selectable wait cycles
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          ram[int'(mem_addr)] = mem_wdata;
          n_wr++;
        end else begin
          mem_rdata = peek(int'(mem_addr));
          rd_addrs.push_back(int'(mem_addr));
          n_rd++;
        end
      end else begin
        wcnt++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // reference model: expected outcome computed from the table contents
  task automatic translate(input bit kern, input int addr, input int latency,
                           input bit intrude, input string tag);
    int p, off, ent, flags, exp_reads, exp_writes, exp_cause, exp_paddr, cyc;
    bit exp_fault, quick;
    p = addr / 512;
    off = addr % 512;
    ent = int'(ptbr) + 2 * p;
    flags = int'(peek(ent + 1));
    exp_fault = 1'b0; exp_cause = 0; exp_paddr = 0; exp_reads = 0; exp_writes = 0;
    quick = 1'b0;
    if (kern) begin
      exp_paddr = addr; quick = 1'b1;
    end else if (p >= int'(ptlr)) begin
      exp_fault = 1'b1; exp_cause = 2; quick = 1'b1;
    end else if (flags[1] == 1'b0) begin
      exp_fault = 1'b1; exp_cause = 0; exp_reads = 1;
    end else begin
      exp_paddr = (int'(peek(ent)) % 64) * 512 + off;
      exp_reads = 2;
      exp_writes = flags[0] ? 0 : 1;
    end
    lat = latency; n_rd = 0; n_wr = 0; rd_addrs.delete();
    @(negedge clk);
    req_valid = 1'b1; req_kernel = kern; req_addr = 15'(addr);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!rsp_valid && cyc < 200) begin
      if (intrude && cyc == 2) begin
        req_valid = 1'b1; req_kernel = 1'b1; req_addr = 15'd77;
      end
      if (intrude && cyc == 5) req_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    check(rsp_valid, {tag, " response seen"}, rsp_valid, 1);
    check(req_ready == 1'b0, {tag, " R8 busy during response"}, req_ready, 0);
    check(rsp_fault == exp_fault, {tag, " fault flag"}, rsp_fault, exp_fault);
    if (exp_fault) begin
      check(int'(rsp_cause) == exp_cause, {tag, " cause"}, rsp_cause, exp_cause);
      check(int'(rsp_badpage) == p, {tag, " bad page"}, rsp_badpage, p);
    end else begin
      check(int'(rsp_paddr) == exp_paddr, {tag, " paddr"}, rsp_paddr, exp_paddr);
    end
    if (quick) check(cyc == 1, {tag, " one-cycle answer"}, cyc, 1);
    check(n_rd == exp_reads, {tag, " R3 read count"}, n_rd, exp_reads);
    check(n_wr == exp_writes, {tag, " R6 R7 write count"}, n_wr, exp_writes);
    if (exp_reads >= 1)
      check(rd_addrs[0] == ent + 1, {tag, " R3 flag word address"}, rd_addrs[0], ent + 1);
    if (exp_reads == 2)
      check(rd_addrs[1] == ent, {tag, " R3 frame word address"}, rd_addrs[1], ent);
    if (exp_writes == 1)
      check(int'(peek(ent + 1)) == (flags | 1), {tag, " R6 flag written"}, peek(ent + 1), flags | 1);
    // R8: nothing further is answered
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!rsp_valid && req_ready, {tag, " R8 no stray response"}, rsp_valid, 0);
    end
  endtask

  initial begin
    ram[1000] = 16'd25;             ram[1001] = 16'h0002; // page 0 valid, unreferenced
    ram[1006] = 16'd40;             ram[1007] = 16'h0003; // page 3 valid, referenced
    ram[1010] = 16'd12;             ram[1011] = 16'h0000; // page 5 absent
    ram[1012] = 16'd13;             ram[1013] = 16'h0001; // page 6 absent, ref set
    ram[1018] = 16'hFFC0 | 16'd63;  ram[1019] = 16'h0006; // page 9 valid, junk upper bits
    repeat (3) @(negedge clk);
    check(!rsp_valid, "R10 rsp_valid after reset", rsp_valid, 0);
    check(req_ready, "R10 req_ready after reset", req_ready, 1);
    check(!mem_req, "R10 mem_req after reset", mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    translate(1'b1, 13532, 0, 1'b0, "R1 kernel");
    translate(1'b1, 32767, 0, 1'b0, "R1 kernel top");
    translate(1'b0, 10 * 512 + 7, 0, 1'b0, "R2 page at limit");
    translate(1'b0, 300, 0, 1'b0, "R5 R6 first touch");
    translate(1'b0, 301, 1, 1'b0, "R7 second touch");
    translate(1'b0, 3 * 512 + 17, 2, 1'b0, "R7 R5 referenced page");
    translate(1'b0, 5 * 512 + 4, 1, 1'b0, "R4 absent");
    translate(1'b0, 6 * 512, 0, 1'b0, "R4 absent ref set");
    translate(1'b0, 9 * 512 + 511, 0, 1'b0, "R2 R5 last legal page");
    translate(1'b0, 9 * 512 + 2, 3, 1'b1, "R8 R9 intruder slow memory");
    ptlr = 7'd0;
    translate(1'b0, 5, 0, 1'b0, "R2 empty table");
    ptlr = 7'd64;
    translate(1'b0, 63 * 512 + 1, 0, 1'b0, "R4 full table unmapped");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule